// File: doc/BRIEF.md
# Multi-Mode Energy Accumulator with Pulse Output

This block integrates signed instantaneous power into energy. It has two channels, active and reactive. Each channel feeds two threshold integrators. The first drives an up/down energy counter. The second drives a frequency-pulse output. A new power sample is captured when `sample_vld` is high. The held sample is then added once for every `acc_tick`, typically 128 ticks per sample.

Each channel has a 2-bit mode. The mode sets how the held sample is shaped before it reaches each integrator. The two integrators of a channel may follow different rules. Active energy can count only positive power while its pulse output stays signed. In one reactive mode, the reactive sample takes its sign from the held active sample.

Energy is counted in units of an 8-bit unsigned threshold. When an integrator's residue reaches plus or minus the threshold, it steps once, subtracts the threshold and keeps the remainder.

Top module: `energy_accum`

## Requirements
- R1: A synchronous active-high `rst` clears the held samples, all residues, both energy counters, all step strobes and both frequency outputs to zero.
- R2: A sample is captured on a clock edge where `sample_vld` is 1. A tick on that same edge still uses the previously held sample.
- R3: On a tick edge, the integrator forms sum = residue + contribution. If sum >= thr, the residue becomes sum - thr and the up strobe (`*_lsb_up_o`) goes high for the next cycle. If sum <= -thr, the residue becomes sum + thr and the down strobe (`*_lsb_dn_o`) goes high. Otherwise the residue becomes sum. The energy counter moves by one on the edge after the strobe.
- R4: An integrator steps at most once per tick. A residue left at or above the threshold is kept and steps on later ticks.
- R5: While `thr` is 0, ticks change no residue, counter, strobe or frequency output.
- R6: Active mode 00 and mode 10 both add the signed active sample to the energy path and to the pulse path.
- R7: Active mode 01 adds the sample to the energy path only when it is positive (otherwise zero). The pulse path still receives the signed sample.
- R8: Active mode 11 adds the magnitude of the sample to both paths.
- R9: Reactive mode 00 and mode 01 both add the signed reactive sample to both paths.
- R10: Reactive mode 10 adds the reactive sample with inverted sign to both paths when the held active sample is negative. When the active sample is zero or positive, the reactive sample is added unchanged.
- R11: Reactive mode 11 adds the magnitude of the reactive sample to the energy path. The pulse path receives the signed sample.
- R12: Each step, up or down, of a channel's pulse path drives `*_freq_o` high for PULSE_W clock cycles. The pulse starts on the cycle after the step strobe. A step during a pulse restarts the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_vld | input | 1 | Capture new power samples |
| act_pwr_i | input | PWR_W | Signed active power sample |
| rea_pwr_i | input | PWR_W | Signed reactive power sample |
| acc_tick | input | 1 | Accumulate held samples on this edge |
| act_mode | input | 2 | Active accumulation mode |
| rea_mode | input | 2 | Reactive accumulation mode |
| thr | input | 8 | Unsigned energy threshold per LSB |
| act_energy_o | output | CNT_W | Signed active energy count |
| rea_energy_o | output | CNT_W | Signed reactive energy count |
| act_lsb_up_o | output | 1 | Active energy stepped up |
| act_lsb_dn_o | output | 1 | Active energy stepped down |
| rea_lsb_up_o | output | 1 | Reactive energy stepped up |
| rea_lsb_dn_o | output | 1 | Reactive energy stepped down |
| act_freq_o | output | 1 | Active frequency pulse output |
| rea_freq_o | output | 1 | Reactive frequency pulse output |

## Verification
The assertions check several rules on every cycle. Up and down strobes never occur together, and they occur only after a tick. The counters move by exactly one after a strobe and hold otherwise. Every rising pulse edge is preceded by a step, and a zero threshold yields no steps. The mode rules can only be shown by the bench's scenarios, which compare final counts and pulse totals against hand-derived values. These include positive-only against signed pulses, magnitude against signed under alternating sign, and reactive sign borrowed from active power. The bench scenarios also cover residue carry-over when a sample exceeds the threshold, clearing of residue by reset, and pulse retriggering.

// File: rtl/energy_pkg.sv
package energy_pkg;

    // Wide signed working type; holds any sample up to 32 bits, its
    // negation and magnitude, plus a residue up to 33 bits.
    localparam int EXT_W = 34;
    typedef logic signed [EXT_W-1:0] ext_t;

    typedef enum logic [1:0] {
        ACT_SIGNED   = 2'b00,
        ACT_POS_ONLY = 2'b01,
        ACT_RSVD     = 2'b10,
        ACT_MAG      = 2'b11
    } act_mode_e;

    typedef enum logic [1:0] {
        REA_SIGNED   = 2'b00,
        REA_RSVD     = 2'b01,
        REA_ACT_SIGN = 2'b10,
        REA_MAG      = 2'b11
    } rea_mode_e;

    // Per-channel contribution: energy path and pulse path
    typedef struct packed {
        ext_t en;
        ext_t pl;
    } contrib_t;

    function automatic ext_t mag(input ext_t v);
        return v[EXT_W-1] ? -v : v;
    endfunction

    function automatic logic is_neg(input ext_t v);
        return v[EXT_W-1];
    endfunction

    // R6 R7 R8
    function automatic ext_t act_energy_val(input logic [1:0] mode, input ext_t v);
        case (mode)
            ACT_POS_ONLY: return is_neg(v) ? '0 : v;
            ACT_MAG:      return mag(v);
            default:      return v;
        endcase
    endfunction

    function automatic ext_t act_pulse_val(input logic [1:0] mode, input ext_t v);
        return (mode == ACT_MAG) ? mag(v) : v;
    endfunction

    // R9 R10 R11
    function automatic ext_t rea_energy_val(input logic [1:0] mode, input ext_t q,
                                            input logic act_negative);
        case (mode)
            REA_ACT_SIGN: return act_negative ? -q : q;
            REA_MAG:      return mag(q);
            default:      return q;
        endcase
    endfunction

    function automatic ext_t rea_pulse_val(input logic [1:0] mode, input ext_t q,
                                           input logic act_negative);
        return (mode == REA_ACT_SIGN && act_negative) ? -q : q;
    endfunction

endpackage

// File: rtl/mode_mapper.sv
module mode_mapper
    import energy_pkg::*;
(
    input  logic [1:0] act_mode_i,
    input  logic [1:0] rea_mode_i,
    input  ext_t       act_i,
    input  ext_t       rea_i,
    output contrib_t   act_o,
    output contrib_t   rea_o
);

    logic act_negative;

    assign act_negative = is_neg(act_i);

    always_comb begin
        act_o.en = act_energy_val(act_mode_i, act_i);
        act_o.pl = act_pulse_val(act_mode_i, act_i);
        rea_o.en = rea_energy_val(rea_mode_i, rea_i, act_negative);
        rea_o.pl = rea_pulse_val(rea_mode_i, rea_i, act_negative);
    end

endmodule

// File: rtl/threshold_integrator.sv
module threshold_integrator
    import energy_pkg::*;
#(
    parameter int RES_W = 24
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick_i,
    input  logic [7:0] thr_i,
    input  ext_t       val_i,
    output logic       up_o,
    output logic       dn_o
);

    localparam ext_t RES_HI = (ext_t'(1) <<< (RES_W-1)) - ext_t'(1);
    localparam ext_t RES_LO = -RES_HI - ext_t'(1);

    logic signed [RES_W-1:0] res_q;
    logic signed [RES_W-1:0] res_d;
    ext_t sum;
    ext_t lim;
    ext_t stepped;
    logic up_d;
    logic dn_d;
    logic thr_zero;

    assign thr_zero = (thr_i == '0);

    always_comb begin
        lim     = ext_t'(thr_i);
        sum     = ext_t'(res_q) + val_i;
        stepped = sum;
        up_d    = 1'b0;
        dn_d    = 1'b0;
        // R3 R4: a single step per tick, remainder kept
        if (!thr_zero) begin
            if (sum >= lim) begin
                stepped = sum - lim;
                up_d    = 1'b1;
            end else if (sum <= -lim) begin
                stepped = sum + lim;
                dn_d    = 1'b1;
            end
        end
        // residue saturates instead of wrapping
        if (stepped > RES_HI)
            res_d = RES_W'(RES_HI);
        else if (stepped < RES_LO)
            res_d = RES_W'(RES_LO);
        else
            res_d = RES_W'(stepped);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            up_o  <= 1'b0;
            dn_o  <= 1'b0;
        end else begin
            up_o <= tick_i & up_d;
            dn_o <= tick_i & dn_d;
            // R5: zero threshold freezes the residue
            if (tick_i && !thr_zero)
                res_q <= res_d;
        end
    end

    // R3
    // step_excl_chk
    step_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o));

    // R3
    // step_needs_tick_chk
    step_needs_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> (!up_o && !dn_o));

endmodule

// File: rtl/energy_counter.sv
module energy_counter #(
    parameter int CNT_W = 24
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    up_i,
    input  logic                    dn_i,
    output logic signed [CNT_W-1:0] count_o
);

    localparam logic signed [CNT_W-1:0] C_ONE = CNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            count_o <= '0;
        else if (up_i && !dn_i)
            count_o <= count_o + C_ONE;
        else if (dn_i && !up_i)
            count_o <= count_o - C_ONE;
    end

    // R3
    // count_inc_chk
    count_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (up_i && !dn_i) |=> count_o == $past(count_o) + C_ONE);

    // R3
    // count_dec_chk
    count_dec_chk: assert property (@(posedge clk) disable iff (rst)
        (dn_i && !up_i) |=> count_o == $past(count_o) - C_ONE);

    // R3
    // count_hold_chk
    count_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!up_i && !dn_i) |=> $stable(count_o));

endmodule

// File: rtl/pulse_stretcher.sv
module pulse_stretcher #(
    parameter int PULSE_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic freq_o
);

    localparam int              PC_W = $clog2(PULSE_W + 1);
    localparam logic [PC_W-1:0] LOAD = PC_W'(PULSE_W);

    logic [PC_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (trig_i)
            cnt_q <= LOAD;          // R12: restart on every step
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign freq_o = (cnt_q != '0);

    // R12
    // freq_rise_chk
    freq_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_o) |-> $past(trig_i));

    // R12
    // freq_load_chk
    freq_load_chk: assert property (@(posedge clk) disable iff (rst)
        trig_i |=> freq_o);

endmodule

// File: rtl/energy_accum.sv
module energy_accum
    import energy_pkg::*;
#(
    parameter int PWR_W   = 16,
    parameter int RES_W   = 24,
    parameter int CNT_W   = 24,
    parameter int PULSE_W = 4
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sample_vld,
    input  logic signed [PWR_W-1:0] act_pwr_i,
    input  logic signed [PWR_W-1:0] rea_pwr_i,
    input  logic                    acc_tick,
    input  logic [1:0]              act_mode,
    input  logic [1:0]              rea_mode,
    input  logic [7:0]              thr,
    output logic signed [CNT_W-1:0] act_energy_o,
    output logic signed [CNT_W-1:0] rea_energy_o,
    output logic                    act_lsb_up_o,
    output logic                    act_lsb_dn_o,
    output logic                    rea_lsb_up_o,
    output logic                    rea_lsb_dn_o,
    output logic                    act_freq_o,
    output logic                    rea_freq_o
);

    localparam int N_CH   = 2;           // active, reactive
    localparam int N_PATH = 2 * N_CH;    // energy and pulse per channel

    // R2: held samples
    logic signed [PWR_W-1:0] act_h;
    logic signed [PWR_W-1:0] rea_h;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_h <= '0;
            rea_h <= '0;
        end else if (sample_vld) begin
            act_h <= act_pwr_i;
            rea_h <= rea_pwr_i;
        end
    end

    contrib_t act_c;
    contrib_t rea_c;

    mode_mapper u_map (
        .act_mode_i (act_mode),
        .rea_mode_i (rea_mode),
        .act_i      (ext_t'(act_h)),
        .rea_i      (ext_t'(rea_h)),
        .act_o      (act_c),
        .rea_o      (rea_c)
    );

    // path index = 2*channel + (0 energy, 1 pulse)
    ext_t              path_val [N_PATH];
    logic [N_PATH-1:0] st_up;
    logic [N_PATH-1:0] st_dn;

    assign path_val[0] = act_c.en;
    assign path_val[1] = act_c.pl;
    assign path_val[2] = rea_c.en;
    assign path_val[3] = rea_c.pl;

    for (genvar p = 0; p < N_PATH; p++) begin : g_int
        threshold_integrator #(.RES_W(RES_W)) u_int (
            .clk    (clk),
            .rst    (rst),
            .tick_i (acc_tick),
            .thr_i  (thr),
            .val_i  (path_val[p]),
            .up_o   (st_up[p]),
            .dn_o   (st_dn[p])
        );
    end

    logic signed [CNT_W-1:0] cnt [N_CH];
    logic [N_CH-1:0]         frq;

    for (genvar c = 0; c < N_CH; c++) begin : g_ch
        energy_counter #(.CNT_W(CNT_W)) u_cnt (
            .clk     (clk),
            .rst     (rst),
            .up_i    (st_up[2*c]),
            .dn_i    (st_dn[2*c]),
            .count_o (cnt[c])
        );
        pulse_stretcher #(.PULSE_W(PULSE_W)) u_ps (
            .clk    (clk),
            .rst    (rst),
            .trig_i (st_up[2*c+1] | st_dn[2*c+1]),
            .freq_o (frq[c])
        );
    end

    assign act_energy_o = cnt[0];
    assign rea_energy_o = cnt[1];
    assign act_lsb_up_o = st_up[0];
    assign act_lsb_dn_o = st_dn[0];
    assign rea_lsb_up_o = st_up[2];
    assign rea_lsb_dn_o = st_dn[2];
    assign act_freq_o   = frq[0];
    assign rea_freq_o   = frq[1];

    // R5
    // zero_thr_chk
    zero_thr_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_tick && thr == '0) |=> (st_up == '0 && st_dn == '0));

endmodule

// File: tb/test_energy_accum.sv
`timescale 1ns/1ps
module test_energy_accum;

    localparam int PWR_W   = 16;
    localparam int CNT_W   = 24;
    localparam int PULSE_W = 4;
    localparam int GAP     = PULSE_W + 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    sample_vld = 1'b0;
    logic signed [PWR_W-1:0] act_pwr = '0;
    logic signed [PWR_W-1:0] rea_pwr = '0;
    logic                    acc_tick = 1'b0;
    logic [1:0]              act_mode = 2'b00;
    logic [1:0]              rea_mode = 2'b00;
    logic [7:0]              thr = 8'd100;
    logic signed [CNT_W-1:0] act_energy;
    logic signed [CNT_W-1:0] rea_energy;
    logic act_up, act_dn, rea_up, rea_dn, act_freq, rea_freq;

    always #4 clk = ~clk;   // 125 MHz

    energy_accum #(.PWR_W(PWR_W), .CNT_W(CNT_W), .PULSE_W(PULSE_W)) i_energy_accum (
        .clk(clk), .rst(rst), .sample_vld(sample_vld),
        .act_pwr_i(act_pwr), .rea_pwr_i(rea_pwr), .acc_tick(acc_tick),
        .act_mode(act_mode), .rea_mode(rea_mode), .thr(thr),
        .act_energy_o(act_energy), .rea_energy_o(rea_energy),
        .act_lsb_up_o(act_up), .act_lsb_dn_o(act_dn),
        .rea_lsb_up_o(rea_up), .rea_lsb_dn_o(rea_dn),
        .act_freq_o(act_freq), .rea_freq_o(rea_freq)
    );

    int n_checks = 0;
    int n_err    = 0;

    // free-running pulse statistics, sampled away from the active edge
    int  a_rise = 0, r_rise = 0, a_high = 0;
    logic a_q = 1'b0, r_q = 1'b0;
    always @(negedge clk) begin
        if (act_freq && !a_q) a_rise++;
        if (rea_freq && !r_q) r_rise++;
        if (act_freq) a_high++;
        a_q = act_freq;
        r_q = rea_freq;
    end

    task automatic check(input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", what, got, exp);
        end
    endtask

    task automatic reset_dut();
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic load(input int a, input int r);
        act_pwr = 16'(a);
        rea_pwr = 16'(r);
        sample_vld = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
    endtask

    task automatic ticks(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            acc_tick = 1'b1;
            @(negedge clk);
            acc_tick = 1'b0;
            repeat (gap) @(negedge clk);
        end
    endtask

    task automatic settle();
        repeat (PULSE_W + 3) @(negedge clk);
    endtask

    // stimulus and expected results (counts from zero after reset)
    typedef struct packed {
        int act; int rea; int am; int rm; int th; int n;
        int e_a; int e_r; int p_a; int p_r;
    } vec_t;

    localparam vec_t VECS [6] = '{
        // R6 R9: signed both channels
        '{30, -20, 0, 0, 100, 10,  3, -2, 3, 2},
        // R7 positive-only energy with signed pulses; R10 active negative
        '{-30, 20, 1, 2, 100, 10,  0, -2, 3, 2},
        // R8 magnitude; R11 magnitude energy, signed pulses
        '{-30, -25, 3, 3, 100, 10, 3, 2, 3, 2},
        // R6 reserved active code, R9 reserved reactive code
        '{45, -45, 2, 1, 100, 10,  4, -4, 4, 4},
        // R10 active positive keeps reactive sign
        '{10, -30, 0, 2, 50, 10,   2, -6, 2, 6},
        // R10 active zero counts as positive; R7 zero adds nothing
        '{0, 15, 1, 2, 30, 8,      0, 4, 0, 4}
    };

    task automatic run_all();
        int ra, rr, hh;

        // R1: state after reset
        reset_dut();
        check("R1 act energy after reset", int'(act_energy), 0);
        check("R1 rea energy after reset", int'(rea_energy), 0);
        check("R1 strobes after reset", int'({act_up, act_dn, rea_up, rea_dn}), 0);
        check("R1 freq after reset", int'({act_freq, rea_freq}), 0);

        // table walk
        for (int v = 0; v < 6; v++) begin
            reset_dut();
            act_mode = 2'(VECS[v].am);
            rea_mode = 2'(VECS[v].rm);
            thr      = 8'(VECS[v].th);
            load(VECS[v].act, VECS[v].rea);
            ra = a_rise; rr = r_rise;
            ticks(VECS[v].n, GAP);
            settle();
            check($sformatf("vec%0d act energy (R6 R7 R8)", v), int'(act_energy), VECS[v].e_a);
            check($sformatf("vec%0d rea energy (R9 R10 R11)", v), int'(rea_energy), VECS[v].e_r);
            check($sformatf("vec%0d act pulses (R7 R12)", v), a_rise - ra, VECS[v].p_a);
            check($sformatf("vec%0d rea pulses (R11 R12)", v), r_rise - rr, VECS[v].p_r);
        end

        // R3 R12: strobe timing and pulse width
        reset_dut();
        act_mode = 2'b00; rea_mode = 2'b00; thr = 8'd100;
        load(100, 0);
        hh = a_high;
        acc_tick = 1'b1;
        @(negedge clk);
        acc_tick = 1'b0;
        check("R3 up strobe after tick", int'(act_up), 1);
        check("R3 no down strobe", int'(act_dn), 0);
        check("R3 energy not yet moved", int'(act_energy), 0);
        check("R12 freq starts one cycle later", int'(act_freq), 0);
        @(negedge clk);
        check("R3 strobe one cycle", int'(act_up), 0);
        check("R3 energy moved", int'(act_energy), 1);
        check("R12 freq high", int'(act_freq), 1);
        settle();
        check("R12 pulse width", a_high - hh, PULSE_W);
        load(-100, 0);
        acc_tick = 1'b1;
        @(negedge clk);
        acc_tick = 1'b0;
        check("R3 down strobe", int'(act_dn), 1);
        settle();
        check("R3 energy stepped down", int'(act_energy), 0);

        // R12: back-to-back steps merge into one longer pulse
        reset_dut();
        load(100, 0);
        ra = a_rise; hh = a_high;
        ticks(2, 0);
        settle();
        check("R12 retrigger single rise", a_rise - ra, 1);
        check("R12 retrigger width", a_high - hh, PULSE_W + 1);

        // R1: mid-run reset clears the residue
        reset_dut();
        load(60, 0);
        ticks(1, 2);
        reset_dut();
        check("R1 energy after mid reset", int'(act_energy), 0);
        load(60, 0);
        ticks(1, 2);
        settle();
        check("R1 residue cleared", int'(act_energy), 0);

        // R5: zero threshold
        reset_dut();
        thr = 8'd0;
        load(50, -50);
        ra = a_rise; rr = r_rise;
        ticks(3, GAP);
        settle();
        check("R5 act energy frozen", int'(act_energy), 0);
        check("R5 rea energy frozen", int'(rea_energy), 0);
        check("R5 no pulses", (a_rise - ra) + (r_rise - rr), 0);
        thr = 8'd100;
        ticks(1, 2);
        settle();
        check("R5 residue untouched by zero thr", int'(act_energy), 0);

        // R4: one step per tick, remainder kept
        reset_dut();
        load(250, 0);
        ra = a_rise;
        ticks(2, GAP);
        settle();
        check("R4 one step per tick", int'(act_energy), 2);
        load(0, 0);
        ticks(1, GAP);
        settle();
        check("R4 kept residue steps later", int'(act_energy), 3);
        check("R4 pulse path steps", a_rise - ra, 3);

        // R8 versus R6 under alternating sign
        reset_dut();
        act_mode = 2'b11;
        load(30, 0);
        ra = a_rise;
        ticks(5, GAP);
        load(-30, 0);
        ticks(5, GAP);
        settle();
        check("R8 magnitude energy", int'(act_energy), 3);
        check("R8 magnitude pulses", a_rise - ra, 3);
        reset_dut();
        act_mode = 2'b00;
        load(30, 0);
        ra = a_rise;
        ticks(5, GAP);
        load(-30, 0);
        ticks(5, GAP);
        settle();
        check("R6 signed energy", int'(act_energy), 0);
        check("R6 signed pulses", a_rise - ra, 2);

        // R2: tick on the capture edge uses the old sample
        reset_dut();
        load(0, 0);
        act_pwr = 16'(100);
        sample_vld = 1'b1;
        acc_tick = 1'b1;
        @(negedge clk);
        sample_vld = 1'b0;
        acc_tick = 1'b0;
        settle();
        check("R2 capture edge uses old sample", int'(act_energy), 0);
        ticks(1, 2);
        settle();
        check("R2 new sample used next tick", int'(act_energy), 1);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                run_all();
            end
            begin
                repeat (150000) @(posedge clk);
                n_checks++;
                n_err++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule